// File: doc/BRIEF.md
# Raster-Op Colour Expansion Writer

This block takes one bus transfer of pixel data and writes it into a frame store that holds one byte per pixel. Every destination byte goes through a raster operation gated by a plane mask, so the block reads each target byte, combines it and writes it back. The store is a byte-wide memory port with a one-cycle read latency. The block issues one pixel per cycle in a pipeline, so the read of pixel i+1 overlaps the write of pixel i.

Three write paths exist:

- **Expansion path.** A monochrome bit pattern becomes foreground and background pixels. A per-pixel write mask can gate each pixel. Two separate op bits can make cleared bits transparent.
- **Packed path.** Four bytes of the data word are written MSB first.
- **Colour-map path.** Four raw bytes go to a linear byte address and bypass the raster operation.

A transfer that would run past the end of the store is dropped as a whole. When the X-increment flag is set, the block returns an advanced position value after the transfer.

Top module: `rop_expand_writer`

## Requirements
- R1: The raster-op code is op_word bits 11:8, and pm is plane_mask. Each written byte becomes, by code:
  - 0: dst & ~pm
  - 3: (dst & ~pm) | (val & pm)
  - 6: dst ^ (val & pm)
  - 10: dst ^ pm
  - 15: dst | pm
  - any other code: the byte is written back unchanged.
- R2: The pixel count is 1 << access_word[30:27], capped at 8 × the access size in bytes. acc_size encodes the size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R3: The expansion path is selected when access_word[26:24] = 6 and cmap_mode = 0. Its start address is y*FB_W + x, with x = pos_in[12:2] and y = pos_in[22:13]. Pixel i goes to start+i and takes data bit (count-1-i). A set bit writes fg_color through the raster op.
- R4: When op_word[29] = 1, an expansion pixel is written only if its bit in the write mask is set. For 4-byte accesses the mask is write_mask itself. For 2-byte accesses it is write_mask >> 16, and for 1-byte accesses it is write_mask >> 24.
- R5: A clear data bit writes bg_color only when op_word[28] and op_word[1] are both 0. Otherwise no write is made for that pixel.
- R6: If the start address plus the number of bytes to write exceeds FB_W*FB_H, the transfer makes no read or write and gives no position update. done still pulses.
- R7: With incr_x = 1 and no drop, pos_we pulses with done and pos_out = pos_in + (count << 2). In colour-map mode the advance is pos_in + 4. With incr_x = 0 there is no pos_we. When access_word[26:24] is neither 6 nor 3, nothing is written, but the advance still applies.
- R8: The packed path is selected when access_word[26:24] = 3 and cmap_mode = 0. It writes data bytes 31:24, 23:16, 15:8 and 7:0 through the raster op to start+0 .. start+3. When op_word[29] = 1, byte k is written only if write_mask[31-k] is set.
- R9: With cmap_mode = 1, the four data bytes, MSB first, are written unchanged to byte addresses pos_in .. pos_in+3, whatever the raster-op code.
- R10: start is accepted only while busy is low. A transfer that writes N bytes keeps busy high for N+1 cycles; a dropped or empty transfer keeps it high for 1 cycle. done is a one-cycle pulse in the cycle after the last write, with busy low. A start pulse while busy has no effect.
- R11: While reset is held, busy, done, rd_en, wr_en and pos_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken when not busy) |
| incr_x | input | 1 | Advance the position after the transfer |
| cmap_mode | input | 1 | Raw colour-map write path |
| acc_size | input | 2 | Access size code |
| data | input | 32 | Transfer data word |
| op_word | input | 32 | Raster-op and transparency controls |
| access_word | input | 32 | Pixel-count and path fields |
| fg_color | input | 8 | Foreground colour |
| bg_color | input | 8 | Background colour |
| plane_mask | input | 8 | Plane mask for the raster op |
| write_mask | input | 32 | Per-pixel write mask |
| pos_in | input | 32 | Current position register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| pos_we | output | 1 | Position update strobe |
| pos_out | output | 32 | Advanced position |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 8 | Memory write data |

## Verification
The expansion path is tried with several patterns:

- Opaque and transparent colouring, where transparency comes from each of the two op bits in turn. This separates the two transparency rules from a plain foreground/background write.
- Masked transfers at 2-byte and 1-byte sizes. A wrong shift of the write mask shows up here as writes to the wrong pixels.
- A pixel-count field larger than the cap. This exposes a missing clamp to the access size.
- Each raster-op code over a plane mask that covers only part of the byte, on a destination filled with varied bytes. Every code then gives a distinct result.

The packed and colour-map paths are driven with an asymmetric word, so any byte-order error appears. Positions just inside and just outside the end of the store separate a correct bound from an off-by-one drop.

// File: rtl/rop_expand_pkg.sv
package rop_expand_pkg;

  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    PATH_NONE   = 2'd0,
    PATH_EXPAND = 2'd1,
    PATH_PACKED = 2'd2,
    PATH_CMAP   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;

  typedef struct packed {
    path_e       path;
    logic [3:0]  rop;
    logic [7:0]  pmask;
    logic [7:0]  fg;
    logic [7:0]  bg;
    logic [31:0] data;
    logic [31:0] wmask;
    logic        mask_en;
    logic        opaque_bg;
  } xfer_cfg_t;

  // pixels per transfer: power of two from the field, clamped by access size
  function automatic logic [IDX_W:0] pix_count(input logic [3:0] lg,
                                               input logic [1:0] sz);
    logic [IDX_W:0] cap;
    logic [IDX_W:0] raw;
    cap = (sz == 2'd0) ? 7'd8 : (sz == 2'd1) ? 7'd16 : 7'd32;
    raw = (lg > 4'd5) ? 7'd64 : (7'd1 << lg);
    return (raw > cap) ? cap : raw;
  endfunction

  function automatic logic [31:0] align_mask(input logic [31:0] m,
                                             input logic [1:0] sz);
    case (sz)
      2'd0:    return m >> 24;
      2'd1:    return m >> 16;
      default: return m;
    endcase
  endfunction

  function automatic logic [7:0] rop_apply(input logic [3:0] code,
                                           input logic [7:0] pm,
                                           input logic [7:0] dst,
                                           input logic [7:0] src);
    case (code)
      4'd0:    return dst & ~pm;
      4'd3:    return (dst & ~pm) | (src & pm);
      4'd6:    return dst ^ (src & pm);
      4'd10:   return dst ^ pm;
      4'd15:   return dst | pm;
      default: return dst;
    endcase
  endfunction

endpackage

// File: rtl/rop_byte_alu.sv
module rop_byte_alu
  import rop_expand_pkg::*;
(
  input  logic [3:0] code,
  input  logic [7:0] pmask,
  input  logic [7:0] dst,
  input  logic [7:0] src,
  input  logic       raw,
  output logic [7:0] result
);
  logic [7:0] combined;

  always_comb begin
    combined = rop_apply(code, pmask, dst, src);
    result   = raw ? src : combined;
  end
endmodule

// File: rtl/rop_lane_plan.sv
module rop_lane_plan
  import rop_expand_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  xfer_cfg_t         cfg,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W:0]    lanes,
  input  logic [IDX_W-1:0]  idx,
  output logic              lane_en,
  output logic [ADDR_W-1:0] lane_addr,
  output logic [7:0]        lane_val,
  output logic              lane_raw
);
  logic [7:0]     lane_byte [4];
  logic [IDX_W:0] bit_pos;
  logic           pat_bit;
  logic           msk_bit;

  for (genvar k = 0; k < 4; k++) begin : g_byte
    assign lane_byte[k] = cfg.data[31-8*k -: 8];
  end

  always_comb begin
    bit_pos   = lanes - 7'd1 - {1'b0, idx};
    pat_bit   = cfg.data[bit_pos[4:0]];
    msk_bit   = cfg.wmask[bit_pos[4:0]];
    lane_addr = base + ADDR_W'(idx);
    lane_raw  = (cfg.path == PATH_CMAP);
    lane_en   = 1'b0;
    lane_val  = 8'h00;
    case (cfg.path)
      PATH_EXPAND: begin
        lane_val = pat_bit ? cfg.fg : cfg.bg;
        lane_en  = (!cfg.mask_en || msk_bit) && (pat_bit || cfg.opaque_bg);
      end
      PATH_PACKED: begin
        lane_val = lane_byte[idx[1:0]];
        lane_en  = !cfg.mask_en || cfg.wmask[5'd31 - {3'd0, idx[1:0]}];
      end
      PATH_CMAP: begin
        lane_val = lane_byte[idx[1:0]];
        lane_en  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rop_rmw_seq.sv
module rop_rmw_seq
  import rop_expand_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              skip_all,
  input  logic [IDX_W:0]    lanes,
  input  logic              lane_en,
  input  logic [ADDR_W-1:0] lane_addr,
  input  logic [7:0]        lane_val,
  input  logic              lane_raw,
  output logic [IDX_W-1:0]  idx,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              st_valid,
  output logic [ADDR_W-1:0] st_addr,
  output logic [7:0]        st_val,
  output logic              st_raw,
  output logic              xfer_last
);
  seq_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic done_q;

  assign idx       = idx_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign xfer_last = (state_q == ST_RUN) && ({1'b0, idx_q} == lanes - 7'd1);
  assign rd_en     = (state_q == ST_RUN) && lane_en;
  assign rd_addr   = lane_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      done_q   <= 1'b0;
      st_valid <= 1'b0;
      st_addr  <= '0;
      st_val   <= '0;
      st_raw   <= 1'b0;
    end else begin
      done_q   <= (state_q == ST_DRAIN);
      st_valid <= (state_q == ST_RUN) && lane_en;
      st_addr  <= lane_addr;
      st_val   <= lane_val;
      st_raw   <= lane_raw;
      case (state_q)
        ST_IDLE: if (accept) begin
          idx_q   <= '0;
          state_q <= skip_all ? ST_DRAIN : ST_RUN;
        end
        ST_RUN: begin
          idx_q <= idx_q + 1'b1;
          if (xfer_last) state_q <= ST_DRAIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rop_expand_writer.sv
module rop_expand_writer
  import rop_expand_pkg::*;
#(
  parameter int FB_W   = 64,
  parameter int FB_H   = 32,
  parameter int ADDR_W = $clog2(FB_W * FB_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              incr_x,
  input  logic              cmap_mode,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       data,
  input  logic [31:0]       op_word,
  input  logic [31:0]       access_word,
  input  logic [7:0]        fg_color,
  input  logic [7:0]        bg_color,
  input  logic [7:0]        plane_mask,
  input  logic [31:0]       write_mask,
  input  logic [31:0]       pos_in,
  output logic              busy,
  output logic              done,
  output logic              pos_we,
  output logic [31:0]       pos_out,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int FB_SIZE = FB_W * FB_H;

  // start-time decode
  path_e          path_d;
  logic [IDX_W:0] cnt_d;
  logic [IDX_W:0] lanes_d;
  logic [32:0]    base_d;
  logic [32:0]    end_d;
  logic           drop_d;
  logic [31:0]    adv_d;
  logic           accept;
  xfer_cfg_t      cfg_d;

  // latched transfer
  xfer_cfg_t         cfg_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W:0]    lanes_q;
  logic              drop_q;
  logic              incr_q;
  logic [31:0]       pos_next_q;

  // internal events brought out for the checker
  logic              lane_en;
  logic [ADDR_W-1:0] lane_addr;
  logic [7:0]        lane_val;
  logic              lane_raw;
  logic [IDX_W-1:0]  idx;
  logic              st_valid;
  logic [ADDR_W-1:0] st_addr;
  logic [7:0]        st_val;
  logic              st_raw;
  logic              xfer_last;
  logic [7:0]        alu_out;

  assign accept = start && !busy;

  always_comb begin
    if (cmap_mode) path_d = PATH_CMAP;
    else begin
      case (access_word[26:24])
        3'd6:    path_d = PATH_EXPAND;
        3'd3:    path_d = PATH_PACKED;
        default: path_d = PATH_NONE;
      endcase
    end
    cnt_d = pix_count(access_word[30:27], acc_size);
    case (path_d)
      PATH_EXPAND: lanes_d = cnt_d;
      PATH_NONE:   lanes_d = '0;
      default:     lanes_d = 7'd4;
    endcase
    if (path_d == PATH_CMAP) base_d = {1'b0, pos_in};
    else base_d = 33'(pos_in[22:13]) * 33'(FB_W) + 33'(pos_in[12:2]);
    end_d  = base_d + 33'(lanes_d);
    drop_d = end_d > 33'(FB_SIZE);
    adv_d  = (path_d == PATH_CMAP) ? 32'd4 : 32'({cnt_d, 2'b00});

    cfg_d.path      = path_d;
    cfg_d.rop       = op_word[11:8];
    cfg_d.pmask     = plane_mask;
    cfg_d.fg        = fg_color;
    cfg_d.bg        = bg_color;
    cfg_d.data      = data;
    cfg_d.wmask     = (path_d == PATH_EXPAND) ? align_mask(write_mask, acc_size)
                                              : write_mask;
    cfg_d.mask_en   = op_word[29];
    cfg_d.opaque_bg = !op_word[28] && !op_word[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      base_q     <= '0;
      lanes_q    <= '0;
      drop_q     <= 1'b0;
      incr_q     <= 1'b0;
      pos_next_q <= '0;
    end else if (accept) begin
      cfg_q      <= cfg_d;
      base_q     <= base_d[ADDR_W-1:0];
      lanes_q    <= lanes_d;
      drop_q     <= drop_d;
      incr_q     <= incr_x;
      pos_next_q <= pos_in + adv_d;
    end
  end

  rop_lane_plan #(.ADDR_W(ADDR_W)) plan_i (
    .cfg       (cfg_q),
    .base      (base_q),
    .lanes     (lanes_q),
    .idx       (idx),
    .lane_en   (lane_en),
    .lane_addr (lane_addr),
    .lane_val  (lane_val),
    .lane_raw  (lane_raw)
  );

  rop_rmw_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .skip_all  (drop_d || (lanes_d == '0)),
    .lanes     (lanes_q),
    .lane_en   (lane_en),
    .lane_addr (lane_addr),
    .lane_val  (lane_val),
    .lane_raw  (lane_raw),
    .idx       (idx),
    .busy      (busy),
    .done      (done),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .st_val    (st_val),
    .st_raw    (st_raw),
    .xfer_last (xfer_last)
  );

  rop_byte_alu alu_i (
    .code   (cfg_q.rop),
    .pmask  (cfg_q.pmask),
    .dst    (rd_data),
    .src    (st_val),
    .raw    (st_raw),
    .result (alu_out)
  );

  assign wr_en   = st_valid;
  assign wr_addr = st_addr;
  assign wr_data = alu_out;
  assign pos_we  = done && incr_q && !drop_q;
  assign pos_out = pos_next_q;
endmodule

// File: rtl/rop_expand_writer_chk.sv
module rop_expand_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic rd_en,
  input logic wr_en,
  input logic pos_we,
  input logic drop,
  input logic xfer_last
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  write_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R10
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R10
  last_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> busy && !done);

  // R7
  advance_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_we |-> $past(busy));

  // R6
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && drop) |-> (!rd_en && !wr_en));
endmodule

bind rop_expand_writer rop_expand_writer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .pos_we    (pos_we),
  .drop      (drop_q),
  .xfer_last (xfer_last)
);

// File: tb/rop_expand_writer_tb_top.sv
`timescale 1ns/1ps
module rop_expand_writer_tb_top;
  localparam int FB_W = 64;
  localparam int FB_H = 32;
  localparam int SIZE = FB_W * FB_H;
  localparam int AW = $clog2(SIZE);

  logic clk = 1'b0;
  logic rst_n;
  logic start, incr_x, cmap_mode;
  logic [1:0] acc_size;
  logic [31:0] data, op_word, access_word, write_mask, pos_in;
  logic [7:0] fg_color, bg_color, plane_mask;
  logic busy, done, pos_we, rd_en, wr_en;
  logic [31:0] pos_out;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  logic [7:0] mem [SIZE];

  typedef struct { int a; logic [7:0] d; string t; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rop_expand_writer #(.FB_W(FB_W), .FB_H(FB_H)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .incr_x(incr_x),
    .cmap_mode(cmap_mode), .acc_size(acc_size), .data(data),
    .op_word(op_word), .access_word(access_word), .fg_color(fg_color),
    .bg_color(bg_color), .plane_mask(plane_mask), .write_mask(write_mask),
    .pos_in(pos_in), .busy(busy), .done(done), .pos_we(pos_we),
    .pos_out(pos_out), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] tb_rop(input logic [3:0] c, input logic [7:0] pm,
                                        input logic [7:0] d, input logic [7:0] v);
    logic [7:0] r;
    r = d;
    for (int b = 0; b < 8; b++) begin
      if (pm[b]) begin
        if (c == 4'd0) r[b] = 1'b0;
        else if (c == 4'd3) r[b] = v[b];
        else if (c == 4'd6) r[b] = d[b] ^ v[b];
        else if (c == 4'd10) r[b] = ~d[b];
        else if (c == 4'd15) r[b] = 1'b1;
      end
    end
    return r;
  endfunction

  // memory model: one-cycle read latency
  initial begin
    rd_data = 8'h00;
    for (int i = 0; i < SIZE; i++) mem[i] = 8'(i * 37 + 11);
    forever begin
      @(posedge clk);
      if (wr_en) mem[int'(wr_addr)] <= wr_data;
      if (rd_en) rd_data <= mem[int'(rd_addr)];
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && wr_en === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(0, "R6", "unexpected write addr", longint'(wr_addr), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(wr_addr) == e.a, e.t, "write address", longint'(wr_addr), e.a);
          check(wr_data == e.d, e.t, "write data", longint'(wr_data), longint'(e.d));
        end
      end
    end
  end

  task automatic push(input int a, input logic [7:0] d, input string t);
    exp_t e;
    e.a = a; e.d = d; e.t = t;
    exp_q.push_back(e);
  endtask

  task automatic run_xfer(input string req, input bit cm, input logic [1:0] sz,
                          input logic [31:0] acc, input logic [31:0] op,
                          input logic [31:0] d, input logic [31:0] wm,
                          input logic [7:0] pm, input logic [31:0] pos,
                          input bit ix, input int poke);
    int path, cnt, lanes, bytes_n, nbusy, cyc;
    longint base;
    bit drop, seen_done;
    path = cm ? 3 : (acc[26:24] == 3'd6) ? 1 : (acc[26:24] == 3'd3) ? 2 : 0;
    bytes_n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    cnt = (acc[30:27] > 4'd5) ? 32 : (1 << acc[30:27]);
    if (cnt > 8 * bytes_n) cnt = 8 * bytes_n;
    lanes = (path == 1) ? cnt : (path == 0) ? 0 : 4;
    base = cm ? longint'(pos) : longint'(pos[22:13]) * FB_W + longint'(pos[12:2]);
    drop = (base + lanes) > SIZE;
    if (!drop) begin
      if (path == 1) begin
        for (int i = 0; i < cnt; i++) begin
          int b;
          bit dbit, mbit;
          b = cnt - 1 - i;
          dbit = d[b];
          mbit = (sz == 2'd0) ? wm[b + 24] : (sz == 2'd1) ? wm[b + 16] : wm[b];
          if (!op[29] || mbit) begin
            if (dbit)
              push(int'(base) + i, tb_rop(op[11:8], pm, mem[int'(base) + i], fg_color), req);
            else if (!op[28] && !op[1])
              push(int'(base) + i, tb_rop(op[11:8], pm, mem[int'(base) + i], bg_color), req);
          end
        end
      end else if (path == 2) begin
        for (int k = 0; k < 4; k++)
          if (!op[29] || wm[31 - k])
            push(int'(base) + k, tb_rop(op[11:8], pm, mem[int'(base) + k], d[31 - 8*k -: 8]), req);
      end else if (path == 3) begin
        for (int k = 0; k < 4; k++) push(int'(base) + k, d[31 - 8*k -: 8], req);
      end
    end
    @(negedge clk);
    cmap_mode = cm; acc_size = sz; access_word = acc; op_word = op; data = d;
    write_mask = wm; plane_mask = pm; pos_in = pos; incr_x = ix; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nbusy = 0; cyc = 0; seen_done = 0;
    while (cyc < 300) begin
      if (done) begin seen_done = 1; break; end
      if (busy) nbusy++;
      start = (cyc == poke);
      if (cyc == poke) data = ~d;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(seen_done, "R10", {req, " done seen"}, seen_done, 1);
    check(!busy, "R10", {req, " busy low at done"}, busy, 0);
    check(nbusy == ((drop || lanes == 0) ? 1 : lanes + 1), "R10",
          {req, " busy cycles"}, nbusy, (drop || lanes == 0) ? 1 : lanes + 1);
    check(pos_we == (ix && !drop), "R7", {req, " pos_we"}, pos_we, ix && !drop);
    if (ix && !drop)
      check(pos_out == pos + (cm ? 32'd4 : 32'(cnt * 4)), "R7", {req, " pos_out"},
            pos_out, pos + (cm ? 32'd4 : 32'(cnt * 4)));
    check(exp_q.size() == 0, req, "missing writes", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done && !busy, "R10", {req, " done one cycle"}, done, 0);
  endtask

  function automatic logic [31:0] xy(input int x, input int y);
    return (32'(y) << 13) | (32'(x) << 2);
  endfunction

  function automatic logic [31:0] acc_w(input int lg, input int len);
    return (32'(lg) << 27) | (32'(len) << 24);
  endfunction

  initial begin
    rst_n = 1'b0; start = 0; incr_x = 0; cmap_mode = 0; acc_size = 0;
    data = 0; op_word = 0; access_word = 0; write_mask = 0; pos_in = 0;
    fg_color = 8'h5C; bg_color = 8'h31; plane_mask = 8'hFF;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !rd_en && !wr_en && !pos_we, "R11", "outputs in reset",
          {busy, done, rd_en, wr_en, pos_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R5 opaque expansion, copy
    run_xfer("R3", 0, 2'd2, acc_w(3, 6), 32'h300, 32'hA5, 0, 8'hFF, xy(5, 2), 1, -1);
    // R5 transparency from op bit 1 and from op bit 28
    run_xfer("R5", 0, 2'd2, acc_w(3, 6), 32'h302, 32'h96, 0, 8'hFF, xy(20, 3), 1, -1);
    run_xfer("R5", 0, 2'd2, acc_w(3, 6), 32'h1000_0300, 32'h3C, 0, 8'hFF, xy(30, 3), 1, -1);
    // R4 write mask, 2-byte and 4-byte access
    run_xfer("R4", 0, 2'd1, acc_w(4, 6), 32'h2000_0300, 32'h1234, 32'hF0C3_0000, 8'hFF, xy(0, 5), 1, -1);
    run_xfer("R4", 0, 2'd2, acc_w(5, 6), 32'h2000_0300, 32'h8F01_22F0, 32'h0FF0_A5C3, 8'hFF, xy(0, 7), 1, -1);
    // R2 count capped by a 1-byte access, mask from top byte
    run_xfer("R2", 0, 2'd0, acc_w(5, 6), 32'h2000_0300, 32'hC3, 32'h5A00_0000, 8'hFF, xy(10, 9), 1, -1);
    run_xfer("R2", 0, 2'd2, acc_w(1, 6), 32'h300, 32'h2, 0, 8'hFF, xy(40, 9), 1, -1);
    // R1 each raster-op code with a partial plane mask
    run_xfer("R1", 0, 2'd2, acc_w(2, 6), 32'h000, 32'h5, 0, 8'h3C, xy(0, 11), 1, -1);
    run_xfer("R1", 0, 2'd2, acc_w(2, 6), 32'h600, 32'h5, 0, 8'h0F, xy(8, 11), 1, -1);
    run_xfer("R1", 0, 2'd2, acc_w(2, 6), 32'hA00, 32'h5, 0, 8'h3C, xy(16, 11), 1, -1);
    run_xfer("R1", 0, 2'd2, acc_w(2, 6), 32'hF00, 32'h5, 0, 8'h81, xy(24, 11), 1, -1);
    run_xfer("R1", 0, 2'd2, acc_w(2, 6), 32'h500, 32'h5, 0, 8'hFF, xy(32, 11), 1, -1);
    // R8 packed path with byte gating
    run_xfer("R8", 0, 2'd2, acc_w(2, 3), 32'h2000_0300, 32'hDEAD_BEEF, 32'hA000_0000, 8'hF0, xy(4, 13), 1, -1);
    run_xfer("R8", 0, 2'd2, acc_w(2, 3), 32'h600, 32'h1357_9BDF, 0, 8'hFF, xy(12, 13), 1, -1);
    // R9 colour-map path bypasses the raster op
    run_xfer("R9", 1, 2'd2, acc_w(3, 6), 32'h000, 32'h1122_3344, 0, 8'hFF, 32'd100, 1, -1);
    // R6 bounds: exact fit, just over, colour-map over
    run_xfer("R6", 0, 2'd2, acc_w(3, 6), 32'h300, 32'hF0, 0, 8'hFF, xy(56, 31), 1, -1);
    run_xfer("R6", 0, 2'd2, acc_w(3, 6), 32'h300, 32'hF0, 0, 8'hFF, xy(60, 31), 1, -1);
    run_xfer("R6", 1, 2'd2, acc_w(3, 6), 32'h300, 32'hFFFF_FFFF, 0, 8'hFF, 32'd2046, 1, -1);
    // R7 no advance without incr_x; unknown length code still advances
    run_xfer("R7", 0, 2'd2, acc_w(3, 6), 32'h300, 32'h81, 0, 8'hFF, xy(0, 15), 0, -1);
    run_xfer("R7", 0, 2'd2, acc_w(2, 0), 32'h300, 32'hFF, 0, 8'hFF, xy(0, 16), 1, -1);
    // R10 start while busy is ignored
    run_xfer("R10", 0, 2'd2, acc_w(3, 6), 32'h300, 32'h6B, 0, 8'hFF, xy(0, 17), 1, 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule